// File: doc/BRIEF.md
# Access-Aware Refresh Sequencer for Dynamic Cache Lines

This block decides when each line of a small cache built from dynamic memory cells gets refreshed. Each line holds its contents for a fixed retention period. A read, a write or a fill restores the cells, so the block restarts that line's retention timer on every access. It asks for a refresh only when a valid line has gone untouched for nearly a full retention period. A global prescaler divides the clock into retention ticks, and each line's timer counts those ticks.

Each line also counts how many whole retention periods have passed since it was last accessed. When a line falls due, the block compares that count with one of two programmable limits. The clean-line limit is the lower one and the dirty-line limit the higher one, because dropping a dirty line costs a writeback as well as a later refetch. Below its limit the line is refreshed. At or above its limit the line is dropped. A clean line is simply invalidated. A dirty line is first written back through a request/acknowledge handshake, then invalidated one cycle after the acknowledge. An access that arrives while that writeback is outstanding rescues the line: it stays valid and becomes clean.

The block holds no data, tags or lower memory levels. It only tracks per-line valid, dirty and age state and issues one command at a time. When several lines are due together, the lowest line index is served first.

Top module: `rfr_ctrl`

## Requirements
- R1: A valid line is never left unserviced for RET_TICKS retention ticks (RET_TICKS*TICK_DIV cycles) after its last access or refresh, provided acknowledges come within a few cycles.
- R2: An access with `acc_fill`=1 makes the line valid, sets dirty to `acc_write`, and clears its timer and idle count. An access with `acc_fill`=0 to an invalid line is ignored: that line never gets a refresh, writeback or invalidate.
- R3: An access with `acc_fill`=0 to a valid line restarts its timer and clears its idle count; `acc_write`=1 also marks it dirty. The block never requests a refresh until the line's timer has reached RET_TICKS-GUARD ticks since its last access or refresh.
- R4: Each refresh acknowledged with no access to that line during the request raises the line's idle count by one (saturating). A due clean line whose idle count is at least `thr_clean` is invalidated with a one-cycle `inv_pulse`, without any refresh or writeback.
- R5: A due dirty line is refreshed while its idle count is below `thr_dirty`, even if the count is at or above `thr_clean`. At or above `thr_dirty`, the line gets a writeback request instead of a refresh.
- R6: `wb_req` stays high with `wb_idx` stable until `wb_ack`. Unless the drop is cancelled, `inv_pulse` is high with `inv_idx` equal to that line in the cycle right after the acknowledge.
- R7: An access to the line during its pending writeback (up to and including the acknowledge cycle) cancels the drop. The writeback completes, no invalidate follows, and the line stays valid and clean with its idle count cleared.
- R8: At most one of `ref_req` and `wb_req` is high at a time. Among lines due together, the lowest index is served first.
- R9: After reset all lines are invalid and `ref_req`, `wb_req` and `inv_pulse` are low.
- R10: `ref_req` stays high with `ref_idx` stable until `ref_ack`. Only valid lines are ever refreshed or written back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_clean | input | IDLE_W | Idle periods after which a clean line is dropped |
| thr_dirty | input | IDLE_W | Idle periods after which a dirty line is dropped (larger than thr_clean) |
| acc_valid | input | 1 | Access event this cycle |
| acc_idx | input | IDX_W | Line index of the access |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_fill | input | 1 | 1 = fill (line becomes valid) |
| ref_req | output | 1 | Refresh command request |
| ref_idx | output | IDX_W | Line to refresh |
| ref_ack | input | 1 | Refresh done |
| wb_req | output | 1 | Writeback request |
| wb_idx | output | IDX_W | Line to write back |
| wb_ack | input | 1 | Writeback accepted by lower level |
| inv_pulse | output | 1 | One-cycle invalidate |
| inv_idx | output | IDX_W | Line being invalidated |

## Verification
The assertions assume that the acknowledge for any request arrives within a handful of cycles, so that the guard margin covers the whole service queue. They also assume that acknowledges are raised only while the matching request is high, that `acc_idx` is below LINES, and that the two thresholds stay constant while lines are live. The stimulus randomizes acknowledge latency between zero and three cycles. Directed holds never exceed twenty cycles. Access indices are drawn only from the populated range, and the thresholds change only across a reset.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REF  = 2'd1,
    SEQ_WB   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rfr_tick.sv
module rfr_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt == CW'(TICK_DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/rfr_pick.sv
module rfr_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rfr_line.sv
module rfr_line #(
  parameter int RET_TICKS = 64,
  parameter int GUARD     = 16,
  parameter int IDLE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              acc_hit,
  input  logic              acc_fill,
  input  logic              acc_write,
  input  logic              drop,
  input  logic              ref_done,
  input  logic              ref_seen,
  input  logic              keep_clean,
  input  logic [IDLE_W-1:0] thr_clean,
  input  logic [IDLE_W-1:0] thr_dirty,
  output logic              valid_o,
  output logic              dirty_o,
  output logic              due_o,
  output logic              drop_ok_o
);
  localparam int TW = $clog2(RET_TICKS + 1);
  localparam int DUE_AT = RET_TICKS - GUARD;
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic              valid_q, dirty_q;
  logic [TW-1:0]     timer_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b0;
      timer_q <= '0;
      idle_q  <= '0;
    end else begin
      if (valid_q && tick && timer_q != TW'(RET_TICKS)) timer_q <= timer_q + 1'b1;
      if (drop) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        timer_q <= '0;
        idle_q  <= '0;
      end else if (acc_hit && (acc_fill || valid_q)) begin
        valid_q <= 1'b1;
        timer_q <= '0;
        idle_q  <= '0;
        dirty_q <= acc_fill ? acc_write : (dirty_q | acc_write);
      end else if (ref_done) begin
        timer_q <= '0;
        if (!ref_seen && idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
      end
      if (keep_clean) dirty_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign dirty_o   = dirty_q;
  assign due_o     = valid_q && (timer_q >= TW'(DUE_AT));
  assign drop_ok_o = dirty_q ? (idle_q >= thr_dirty) : (idle_q >= thr_clean);

  // R1: a live line never reaches the end of its retention window
  assert_retention_R1: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (timer_q < TW'(RET_TICKS)));

  // R2: a fill always leaves the line valid
  assert_fill_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_hit && acc_fill && !drop) |=> valid_q);
endmodule

// File: rtl/rfr_ctrl.sv
module rfr_ctrl #(
  parameter int LINES     = 8,
  parameter int TICK_DIV  = 4,
  parameter int RET_TICKS = 64,
  parameter int GUARD     = 16,
  parameter int IDLE_W    = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [IDLE_W-1:0]                      thr_clean,
  input  logic [IDLE_W-1:0]                      thr_dirty,
  input  logic                                   acc_valid,
  input  logic [((LINES>1)?$clog2(LINES):1)-1:0] acc_idx,
  input  logic                                   acc_write,
  input  logic                                   acc_fill,
  output logic                                   ref_req,
  output logic [((LINES>1)?$clog2(LINES):1)-1:0] ref_idx,
  input  logic                                   ref_ack,
  output logic                                   wb_req,
  output logic [((LINES>1)?$clog2(LINES):1)-1:0] wb_idx,
  input  logic                                   wb_ack,
  output logic                                   inv_pulse,
  output logic [((LINES>1)?$clog2(LINES):1)-1:0] inv_idx
);
  import rfr_pkg::*;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic              tick;
  logic [LINES-1:0]  valid_v, dirty_v, due_v, dropok_v;
  logic [LINES-1:0]  acc_sel_v, drop_v, refdone_v, keep_v, cand_v;
  logic              any;
  logic [IDX_W-1:0]  pick_idx, pend_idx;
  logic              pend_hit, seen;
  seq_state_t        state;

  rfr_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      assign acc_sel_v[gi] = acc_valid && (acc_idx == IDX_W'(gi));
      rfr_line #(.RET_TICKS(RET_TICKS), .GUARD(GUARD), .IDLE_W(IDLE_W)) u_line (
        .clk(clk), .rst(rst), .tick(tick),
        .acc_hit(acc_sel_v[gi]), .acc_fill(acc_fill), .acc_write(acc_write),
        .drop(drop_v[gi]), .ref_done(refdone_v[gi]), .ref_seen(seen),
        .keep_clean(keep_v[gi]), .thr_clean(thr_clean), .thr_dirty(thr_dirty),
        .valid_o(valid_v[gi]), .dirty_o(dirty_v[gi]), .due_o(due_v[gi]),
        .drop_ok_o(dropok_v[gi]));
    end
  endgenerate

  // a line touched this cycle is refreshed by that access: not a candidate
  assign cand_v = (state == SEQ_IDLE) ? (due_v & ~acc_sel_v) : '0;

  rfr_pick #(.N(LINES), .IW(IDX_W)) u_pick (.req(cand_v), .any(any), .idx(pick_idx));

  assign pend_idx = (state == SEQ_WB) ? wb_idx : ref_idx;
  assign seen     = pend_hit || (acc_valid && acc_idx == pend_idx);

  always_comb begin
    drop_v    = '0;
    refdone_v = '0;
    keep_v    = '0;
    case (state)
      SEQ_IDLE: if (any && dropok_v[pick_idx] && !dirty_v[pick_idx]) drop_v[pick_idx] = 1'b1;
      SEQ_REF:  if (ref_ack) refdone_v[ref_idx] = 1'b1;
      SEQ_WB:   if (wb_ack) begin
                  if (seen) keep_v[wb_idx] = 1'b1;
                  else      drop_v[wb_idx] = 1'b1;
                end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      ref_req   <= 1'b0;
      ref_idx   <= '0;
      wb_req    <= 1'b0;
      wb_idx    <= '0;
      inv_pulse <= 1'b0;
      inv_idx   <= '0;
      pend_hit  <= 1'b0;
    end else begin
      inv_pulse <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (any) begin
            pend_hit <= 1'b0;
            if (dropok_v[pick_idx]) begin
              if (dirty_v[pick_idx]) begin
                wb_req <= 1'b1;
                wb_idx <= pick_idx;
                state  <= SEQ_WB;
              end else begin
                inv_pulse <= 1'b1;
                inv_idx   <= pick_idx;
              end
            end else begin
              ref_req <= 1'b1;
              ref_idx <= pick_idx;
              state   <= SEQ_REF;
            end
          end
        end
        SEQ_REF: begin
          if (acc_valid && acc_idx == ref_idx) pend_hit <= 1'b1;
          if (ref_ack) begin
            ref_req <= 1'b0;
            state   <= SEQ_IDLE;
          end
        end
        SEQ_WB: begin
          if (acc_valid && acc_idx == wb_idx) pend_hit <= 1'b1;
          if (wb_ack) begin
            wb_req <= 1'b0;
            state  <= SEQ_IDLE;
            if (!seen) begin
              inv_pulse <= 1'b1;
              inv_idx   <= wb_idx;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R10: refresh request held with stable index until acknowledged
  assert_ref_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> (ref_req && $stable(ref_idx)));

  // R6: writeback request held with stable index until acknowledged
  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  // R6: uncancelled writeback is followed by the invalidate of that line
  assert_inv_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_ack && !seen) |=> (inv_pulse && inv_idx == $past(wb_idx)));

  // R7: a cancelled writeback produces no invalidate
  assert_cancel_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_ack && seen) |=> !inv_pulse);

  // R8: one command at a time
  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_req, wb_req}));

  // R10: only valid lines are refreshed
  assert_ref_valid_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_req) |-> valid_v[ref_idx]);

  // R5: writebacks only for valid dirty lines
  assert_wb_dirty_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> (valid_v[wb_idx] && dirty_v[wb_idx]));
endmodule

// File: tb/rfr_ctrl_test.sv
module rfr_ctrl_test;
  localparam int N = 8, DIV = 4, RET = 64, GRD = 16, IW = 3, XW = 3;
  localparam int WIN_LO = (RET - GRD - 1) * DIV + 1;
  localparam int WIN_HI = RET * DIV;

  logic clk = 1'b0, rst = 1'b1;
  logic [IW-1:0] thr_c = 3'd2, thr_d = 3'd4;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_fill = 1'b0;
  logic [XW-1:0] acc_idx = '0;
  logic ref_ack = 1'b0, wb_ack = 1'b0;
  logic ref_req, wb_req, inv_pulse;
  logic [XW-1:0] ref_idx, wb_idx, inv_idx;

  rfr_ctrl #(.LINES(N), .TICK_DIV(DIV), .RET_TICKS(RET), .GUARD(GRD), .IDLE_W(IW)) uut (
    .clk(clk), .rst(rst), .thr_clean(thr_c), .thr_dirty(thr_d),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write), .acc_fill(acc_fill),
    .ref_req(ref_req), .ref_idx(ref_idx), .ref_ack(ref_ack),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
    .inv_pulse(inv_pulse), .inv_idx(inv_idx));

  always #2 clk = ~clk;

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int total = 0, bad = 0;
  bit reported = 0;

  bit m_valid[N], m_dirty[N];
  int m_idle[N], m_touch[N];
  int ref_cnt[N], wb_cnt[N], inv_cnt[N];
  int ref_log[16];
  int log_n;
  bit prev_ref, prev_wb, pend_on, pend_hit, exp_inv, hold_ref, hold_wb, rand_dly;
  int prev_ref_idx, prev_wb_idx, pend_line, exp_inv_idx, rdly, wdly;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  function automatic int limit_of(input int l);
    return m_dirty[l] ? int'(thr_d) : int'(thr_c);
  endfunction

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_idle[i] = 0; m_touch[i] = 0;
      ref_cnt[i] = 0; wb_cnt[i] = 0; inv_cnt[i] = 0;
    end
    log_n = 0; prev_ref = 0; prev_wb = 0; pend_on = 0; pend_hit = 0; exp_inv = 0;
    rdly = 0; wdly = 0;
  endtask

  task automatic step();
    int a;
    @(negedge clk);
    // commit inputs registered at the last edge
    if (acc_valid) begin
      a = int'(acc_idx);
      if (acc_fill) begin
        m_valid[a] = 1; m_dirty[a] = acc_write; m_idle[a] = 0; m_touch[a] = pe;
      end else if (m_valid[a]) begin
        m_idle[a] = 0; m_touch[a] = pe; m_dirty[a] = m_dirty[a] | acc_write;
      end
      if (pend_on && pend_line == a) pend_hit = 1;
    end
    if (prev_ref && ref_ack) begin
      m_touch[prev_ref_idx] = pe;
      if (!pend_hit && m_idle[prev_ref_idx] < 7) m_idle[prev_ref_idx]++;
      pend_on = 0;
    end
    if (prev_wb && wb_ack) begin
      if (pend_hit) m_dirty[prev_wb_idx] = 0;
      else begin
        m_valid[prev_wb_idx] = 0; m_dirty[prev_wb_idx] = 0;
        exp_inv = 1; exp_inv_idx = prev_wb_idx;
      end
      pend_on = 0;
    end
    // observe outputs
    if (inv_pulse) begin
      a = int'(inv_idx);
      inv_cnt[a]++;
      if (exp_inv) chk(a == exp_inv_idx, "R6 invalidate after writeback ack", a, exp_inv_idx);
      else begin
        chk(m_valid[a] && !m_dirty[a], "R4 clean drop of valid clean line", m_dirty[a], 0);
        chk(m_idle[a] >= int'(thr_c), "R4 clean drop idle count", m_idle[a], int'(thr_c));
        chk(pe - m_touch[a] >= WIN_LO, "R3 drop not before due", pe - m_touch[a], WIN_LO);
        m_valid[a] = 0;
      end
    end else if (exp_inv) chk(0, "R6 missing invalidate", 0, 1);
    exp_inv = 0;
    if (ref_req && !prev_ref) begin
      a = int'(ref_idx);
      ref_cnt[a]++;
      if (log_n < 16) begin ref_log[log_n] = a; log_n++; end
      chk(m_valid[a], "R10 refresh of valid line", 0, 1);
      chk(m_idle[a] < limit_of(a), "R5 refresh below threshold", m_idle[a], limit_of(a));
      chk(pe - m_touch[a] >= WIN_LO, "R3 refresh not early", pe - m_touch[a], WIN_LO);
      chk(pe - m_touch[a] < WIN_HI, "R1 refresh in retention", pe - m_touch[a], WIN_HI);
      pend_on = 1; pend_line = a; pend_hit = 0;
      rdly = rand_dly ? int'($urandom % 4) : 0;
    end else if (ref_req) chk(int'(ref_idx) == prev_ref_idx, "R10 ref_idx stable", ref_idx, prev_ref_idx);
    if (wb_req && !prev_wb) begin
      a = int'(wb_idx);
      wb_cnt[a]++;
      chk(m_valid[a] && m_dirty[a], "R5 writeback of valid dirty line", m_dirty[a], 1);
      chk(m_idle[a] >= int'(thr_d), "R5 writeback idle count", m_idle[a], int'(thr_d));
      pend_on = 1; pend_line = a; pend_hit = 0;
      wdly = rand_dly ? int'($urandom % 4) : 0;
    end else if (wb_req) chk(int'(wb_idx) == prev_wb_idx, "R6 wb_idx stable", wb_idx, prev_wb_idx);
    chk(!(ref_req && wb_req), "R8 single command", {ref_req, wb_req}, 0);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && pe - m_touch[i] >= WIN_HI) chk(0, "R1 retention exceeded", pe - m_touch[i], WIN_HI);
    prev_ref = ref_req; prev_ref_idx = int'(ref_idx);
    prev_wb = wb_req;   prev_wb_idx = int'(wb_idx);
    // drive
    acc_valid = 0; acc_fill = 0; acc_write = 0;
    ref_ack = 0; wb_ack = 0;
    if (ref_req && !hold_ref) begin if (rdly == 0) ref_ack = 1; else rdly--; end
    if (wb_req && !hold_wb) begin if (wdly == 0) wb_ack = 1; else wdly--; end
  endtask

  task automatic do_reset(input int c, input int d);
    rst = 1; thr_c = IW'(c); thr_d = IW'(d);
    acc_valid = 0; ref_ack = 0; wb_ack = 0; hold_ref = 0; hold_wb = 0;
    repeat (3) @(negedge clk);
    clear_model();
    chk(!ref_req && !wb_req && !inv_pulse, "R9 reset outputs", {ref_req, wb_req, inv_pulse}, 0);
    rst = 0;
  endtask

  task automatic do_acc(input int l, input bit wr, input bit fill);
    step();
    acc_valid = 1; acc_idx = XW'(l); acc_write = wr; acc_fill = fill;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) step();
  endtask

  initial begin
    int base, guard_n;
    void'($urandom(32'h5eed_0042));
    rand_dly = 0;
    // clean line: two refreshes, then dropped
    do_reset(2, 4);
    do_acc(3, 0, 1);
    wait_cyc(700);
    chk(ref_cnt[3] == 2, "R4 clean line refresh count", ref_cnt[3], 2);
    chk(inv_cnt[3] == 1 && wb_cnt[3] == 0, "R4 clean line dropped once", inv_cnt[3], 1);
    // accesses keep deferring refresh
    do_reset(2, 4);
    do_acc(1, 0, 1);
    repeat (6) begin wait_cyc(150); do_acc(1, 0, 0); end
    chk(ref_cnt[1] == 0, "R3 access defers refresh", ref_cnt[1], 0);
    wait_cyc(200);
    chk(ref_cnt[1] == 1, "R3 refresh after accesses stop", ref_cnt[1], 1);
    // dirty line: refreshed past the clean limit, then written back
    do_reset(2, 4);
    do_acc(4, 1, 1);
    hold_wb = 1;
    guard_n = 0;
    while (!wb_req && guard_n < 3000) begin step(); guard_n++; end
    wait_cyc(5);
    chk(inv_cnt[4] == 0, "R6 no invalidate before ack", inv_cnt[4], 0);
    hold_wb = 0;
    wait_cyc(10);
    chk(ref_cnt[4] == 4, "R5 dirty line refresh count", ref_cnt[4], 4);
    chk(wb_cnt[4] == 1 && inv_cnt[4] == 1, "R6 writeback then invalidate", inv_cnt[4], 1);
    // cancelled writeback
    do_reset(2, 4);
    do_acc(6, 1, 1);
    hold_wb = 1;
    guard_n = 0;
    while (!wb_req && guard_n < 3000) begin step(); guard_n++; end
    wait_cyc(2);
    do_acc(6, 0, 0);
    wait_cyc(2);
    hold_wb = 0;
    wait_cyc(10);
    chk(inv_cnt[6] == 0 && m_valid[6], "R7 cancel keeps line", inv_cnt[6], 0);
    base = ref_cnt[6];
    wait_cyc(700);
    chk(ref_cnt[6] - base == 2, "R7 line clean after cancel", ref_cnt[6] - base, 2);
    chk(inv_cnt[6] == 1 && wb_cnt[6] == 1, "R7 later clean drop", wb_cnt[6], 1);
    // accesses to an invalid line are ignored
    do_reset(2, 4);
    do_acc(7, 0, 0);
    do_acc(7, 1, 0);
    do_acc(7, 0, 0);
    wait_cyc(600);
    chk(ref_cnt[7] + wb_cnt[7] + inv_cnt[7] == 0, "R2 invalid line ignored", ref_cnt[7] + inv_cnt[7], 0);
    // priority: lowest index first
    do_reset(2, 4);
    do_acc(0, 0, 1);
    do_acc(6, 0, 1);
    do_acc(2, 0, 1);
    hold_ref = 1;
    guard_n = 0;
    while (!ref_req && guard_n < 1000) begin step(); guard_n++; end
    wait_cyc(20);
    hold_ref = 0;
    wait_cyc(20);
    chk(log_n == 3, "R8 three refreshes", log_n, 3);
    chk(ref_log[0] == 0, "R8 first served", ref_log[0], 0);
    chk(ref_log[1] == 2, "R8 second served", ref_log[1], 2);
    chk(ref_log[2] == 6, "R8 third served", ref_log[2], 6);
    // constrained random traffic
    do_reset(1, 3);
    rand_dly = 1;
    for (int k = 0; k < 20000; k++) begin
      step();
      if ($urandom % 4 == 0) begin
        acc_valid = 1;
        acc_idx   = XW'($urandom % N);
        acc_fill  = ($urandom % 3 == 0);
        acc_write = $urandom % 2;
      end
    end
    wait_cyc(50);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end
endmodule